// File: doc/BRIEF.md
# Configuration Command Decoder with Readback Select

This block sits behind a serial slave port. The port delivers a received 3-bit register address and a 13-bit data word, with a one-cycle `frameDone` strobe once a frame ends. A one-cycle `csFall` strobe marks the falling edge of chip-select. Frames sent to the configuration address update a set of stored control bits: the zero-position end, the coil phase offset, a disable for the acceleration emulation, and the calibration and power controls. The same frames also set a 3-bit readback selector. That selector chooses which word the next transfer shifts out: the device status, the return-to-zero accumulator with its detect flag, the pointer position, or the velocity-ramp step.

When `csFall` arrives, the word that the selector points to is sampled from the live inputs into a holding register. The shift register then reads a value that cannot change for the rest of the transfer. A null command bit turns a frame into a pure read with no side effects. A frame with the reserved bit set is thrown away and raises a command-error flag. That flag is reported in the status word.

Top module: `cfg_cmd_decoder`

## Requirements
- R1: After reset, all seven configuration outputs are 0, the selector points to device status, the command-error flag is 0 and `rbWord` is 0.
- R2: A frame with `frameAddr` equal to `CFG_ADDR`, data bit 12 = 0 and data bit 8 = 0 is accepted. In the cycle after `frameDone`, the outputs show the new values: bit 7 on `zeroIsCw`, bit 6 on `coilSixty`, bit 5 on `emuOff`, bit 4 on `calCenter`, bit 3 on `calArm`, bit 2 on `calSlow` and bit 0 on `powerOn`.
- R3: A frame to `CFG_ADDR` with data bit 12 = 1 is a null command. It changes neither the configuration outputs nor the selector, whatever bits 11..0 hold, bit 8 included.
- R4: A frame to `CFG_ADDR` with bit 12 = 0 and bit 8 = 1 is discarded. Configuration and selector keep their values, and the command-error flag is set.
- R5: The command-error flag stays set until the next accepted or null frame to `CFG_ADDR` clears it.
- R6: Frames to any address other than `CFG_ADDR` change no configuration output, no selector state and no error flag.
- R7: The selector is data bits 11..9. Code 0xx selects status = {error flag, `statusIn`}. Code 10x selects {`rtzFlag`, `accIn`}. Code 110 selects `posIn`. Code 111 selects `stepIn`.
- R8: The selector written by a frame is used at the next `csFall`. `rbWord` takes the selected value, as present in the `csFall` cycle, in the cycle that follows.
- R9: `rbWord` holds its value between `csFall` strobes, whatever the live inputs do.
- R10: Data bit 1 has no effect: an accepted frame with bit 1 set acts the same as one with bit 1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameDone | input | 1 | One-cycle strobe: a received frame is complete |
| frameAddr | input | ADDR_W | Received register address |
| frameData | input | 13 | Received data word |
| csFall | input | 1 | One-cycle strobe on the chip-select falling edge |
| statusIn | input | WORD_W-1 | Live device status bits |
| accIn | input | WORD_W-1 | Live return-to-zero accumulator |
| rtzFlag | input | 1 | Live return-to-zero detection status |
| posIn | input | WORD_W | Live pointer position |
| stepIn | input | WORD_W | Live velocity-ramp step position |
| zeroIsCw | output | 1 | Zero position at the clockwise end |
| coilSixty | output | 1 | Coil phase offset 60° (else 90°) |
| emuOff | output | 1 | Acceleration emulation disabled |
| calCenter | output | 1 | Calibrated clock centred on nominal |
| calArm | output | 1 | Calibration request |
| calSlow | output | 1 | Oscillator slowed for a long calibration pulse |
| powerOn | output | 1 | Power enable |
| rbWord | output | WORD_W | Held readback word for the shifter |

## Verification
The decoder is driven with random frames that mix accepted writes, null commands, reserved-bit rejects and writes to other addresses. Each frame is followed by a chip-select snapshot taken while the live inputs change at random. A wrong rbWord after a null or rejected frame shows that the selector was updated when it must not be. A wrong configuration value points to the write path or the bit mapping. Directed cases cover each selector code on its own and the set and clear of the error flag. They also check a frame that sets only bit 1, and input changes made after a snapshot, which tell a real holding register apart from a pass-through.

// File: rtl/cfg_cmd_pkg.sv
package cfg_cmd_pkg;

  // Command word layout; positions are decoded by the host, so they are fixed.
  localparam int CMD_W   = 13;
  localparam int B_NULL  = 12;
  localparam int B_SRC   = 11;
  localparam int B_GRP   = 10;
  localparam int B_SUB   = 9;
  localparam int B_RSV   = 8;
  localparam int B_ZERO  = 7;
  localparam int B_COIL  = 6;
  localparam int B_EMU   = 5;
  localparam int B_CCTR  = 4;
  localparam int B_CARM  = 3;
  localparam int B_CSLOW = 2;
  localparam int B_PWR   = 0;
  localparam int SEL_W   = 3;

  typedef enum logic [1:0] {
    SRC_STATUS = 2'd0,
    SRC_ACCUM  = 2'd1,
    SRC_POS    = 2'd2,
    SRC_STEP   = 2'd3
  } rbSrc_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadCfg;
    logic loadSel;
    logic setErr;
    logic clrErr;
  } ctrlStrb_t;

  typedef struct packed {
    logic zeroIsCw;
    logic coilSixty;
    logic emuOff;
    logic calCenter;
    logic calArm;
    logic calSlow;
    logic powerOn;
  } cfgBits_t;

  // Hierarchical selector: top bit picks status vs data, then group, then sub.
  function automatic rbSrc_e decodeSel(input logic [SEL_W-1:0] code);
    if (!code[2])      return SRC_STATUS;
    else if (!code[1]) return SRC_ACCUM;
    else if (!code[0]) return SRC_POS;
    else               return SRC_STEP;
  endfunction

endpackage

// File: rtl/cfg_cmd_ctrl.sv
module cfg_cmd_ctrl
  import cfg_cmd_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CFG_ADDR = 0
) (
  input  logic              frameDone,
  input  logic [ADDR_W-1:0] frameAddr,
  input  logic              nullBit,
  input  logic              rsvBit,
  output ctrlStrb_t         strb
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_ADDR);

  logic hitAddr;
  logic isNull;
  logic isBad;
  logic isGood;

  always_comb begin
    hitAddr = frameDone && (frameAddr == MY_ADDR);
    // Null takes precedence: every lower bit, reserved included, is ignored.
    isNull  = hitAddr && nullBit;
    isBad   = hitAddr && !nullBit && rsvBit;
    isGood  = hitAddr && !nullBit && !rsvBit;

    strb.loadCfg = isGood;
    strb.loadSel = isGood;
    strb.setErr  = isBad;
    strb.clrErr  = isGood || isNull;
  end

endmodule

// File: rtl/cfg_cmd_dpath.sv
module cfg_cmd_dpath
  import cfg_cmd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  cfgBits_t          cfgNext,
  input  logic [SEL_W-1:0]  selNext,
  input  logic              csFall,
  input  logic [WORD_W-2:0] statusIn,
  input  logic [WORD_W-2:0] accIn,
  input  logic              rtzFlag,
  input  logic [WORD_W-1:0] posIn,
  input  logic [WORD_W-1:0] stepIn,
  output cfgBits_t          cfgQ,
  output logic [WORD_W-1:0] rbWord
);

  logic [SEL_W-1:0]  selQ;
  logic              errQ;
  rbSrc_e            srcNow;
  logic [WORD_W-1:0] statusWord;
  logic [WORD_W-1:0] accWord;
  logic [WORD_W-1:0] pickWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      selQ <= '0;
    end else begin
      if (strb.loadCfg) cfgQ <= cfgNext;
      if (strb.loadSel) selQ <= selNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errQ <= 1'b0;
    else if (strb.setErr) errQ <= 1'b1;
    else if (strb.clrErr) errQ <= 1'b0;
  end

  always_comb begin
    srcNow     = decodeSel(selQ);
    statusWord = {errQ, statusIn};
    accWord    = {rtzFlag, accIn};
    unique case (srcNow)
      SRC_STATUS: pickWord = statusWord;
      SRC_ACCUM:  pickWord = accWord;
      SRC_POS:    pickWord = posIn;
      SRC_STEP:   pickWord = stepIn;
      default:    pickWord = statusWord;
    endcase
  end

  // Snapshot on chip-select fall; held for the whole transfer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rbWord <= '0;
    else if (csFall) rbWord <= pickWord;
  end

endmodule

// File: rtl/cfg_cmd_decoder.sv
module cfg_cmd_decoder
  import cfg_cmd_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CFG_ADDR = 0,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic [ADDR_W-1:0] frameAddr,
  input  logic [CMD_W-1:0]  frameData,
  input  logic              csFall,
  input  logic [WORD_W-2:0] statusIn,
  input  logic [WORD_W-2:0] accIn,
  input  logic              rtzFlag,
  input  logic [WORD_W-1:0] posIn,
  input  logic [WORD_W-1:0] stepIn,
  output logic              zeroIsCw,
  output logic              coilSixty,
  output logic              emuOff,
  output logic              calCenter,
  output logic              calArm,
  output logic              calSlow,
  output logic              powerOn,
  output logic [WORD_W-1:0] rbWord
);

  ctrlStrb_t        strb;
  cfgBits_t         cfgNext;
  cfgBits_t         cfgQ;
  logic [SEL_W-1:0] selNext;
  logic             unusedBits;

  assign unusedBits = frameData[1];

  always_comb begin
    cfgNext.zeroIsCw  = frameData[B_ZERO];
    cfgNext.coilSixty = frameData[B_COIL];
    cfgNext.emuOff    = frameData[B_EMU];
    cfgNext.calCenter = frameData[B_CCTR];
    cfgNext.calArm    = frameData[B_CARM];
    cfgNext.calSlow   = frameData[B_CSLOW];
    cfgNext.powerOn   = frameData[B_PWR];
    selNext = {frameData[B_SRC], frameData[B_GRP], frameData[B_SUB]};
  end

  cfg_cmd_ctrl #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) ctrl_i (
    .frameDone (frameDone),
    .frameAddr (frameAddr),
    .nullBit   (frameData[B_NULL]),
    .rsvBit    (frameData[B_RSV]),
    .strb      (strb)
  );

  cfg_cmd_dpath #(.WORD_W(WORD_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgNext  (cfgNext),
    .selNext  (selNext),
    .csFall   (csFall),
    .statusIn (statusIn),
    .accIn    (accIn),
    .rtzFlag  (rtzFlag),
    .posIn    (posIn),
    .stepIn   (stepIn),
    .cfgQ     (cfgQ),
    .rbWord   (rbWord)
  );

  assign zeroIsCw  = cfgQ.zeroIsCw;
  assign coilSixty = cfgQ.coilSixty;
  assign emuOff    = cfgQ.emuOff;
  assign calCenter = cfgQ.calCenter;
  assign calArm    = cfgQ.calArm;
  assign calSlow   = cfgQ.calSlow;
  assign powerOn   = cfgQ.powerOn;

endmodule

// File: rtl/cfg_cmd_decoder_chk.sv
module cfg_cmd_decoder_chk #(
  parameter int ADDR_W   = 3,
  parameter int CFG_ADDR = 0,
  parameter int WORD_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameDone,
  input logic [ADDR_W-1:0] frameAddr,
  input logic [12:0]       frameData,
  input logic              csFall,
  input logic [6:0]        cfgOut,
  input logic [WORD_W-1:0] rbWord
);

  logic hit;
  assign hit = frameDone && (frameAddr == ADDR_W'(CFG_ADDR));

  // R2: accepted write lands on the outputs one cycle later
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !frameData[12] && !frameData[8]) |=>
      (cfgOut == {$past(frameData[7:2]), $past(frameData[0])}));

  // R3: null command leaves configuration untouched
  p_null_keeps_cfg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hit && frameData[12]) |=> $stable(cfgOut));

  // R4: rejected frame leaves configuration untouched
  p_reject_keeps_cfg_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !frameData[12] && frameData[8]) |=> $stable(cfgOut));

  // R6: other addresses are ignored
  p_other_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !hit) |=> $stable(cfgOut));

  // R9: readback word only moves after a chip-select fall
  p_word_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    !csFall |=> $stable(rbWord));

endmodule

bind cfg_cmd_decoder cfg_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .WORD_W(WORD_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .frameDone (frameDone),
  .frameAddr (frameAddr),
  .frameData (frameData),
  .csFall    (csFall),
  .cfgOut    ({zeroIsCw, coilSixty, emuOff, calCenter, calArm, calSlow, powerOn}),
  .rbWord    (rbWord)
);

// File: tb/cfg_cmd_decoder_tb.sv
module cfg_cmd_decoder_tb_top;

  localparam int ADDR_W = 3;
  localparam int WORD_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              frameDone = 1'b0;
  logic [ADDR_W-1:0] frameAddr = '0;
  logic [12:0]       frameData = '0;
  logic              csFall = 1'b0;
  logic [WORD_W-2:0] statusIn = '0;
  logic [WORD_W-2:0] accIn = '0;
  logic              rtzFlag = 1'b0;
  logic [WORD_W-1:0] posIn = '0;
  logic [WORD_W-1:0] stepIn = '0;
  logic              zeroIsCw, coilSixty, emuOff, calCenter, calArm, calSlow, powerOn;
  logic [WORD_W-1:0] rbWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model
  logic [6:0] mCfg = '0;
  logic [2:0] mSel = '0;
  logic       mErr = 1'b0;
  logic [WORD_W-1:0] mWord = '0;

  always #2.5 clk = ~clk;

  cfg_cmd_decoder #(.ADDR_W(ADDR_W), .CFG_ADDR(0), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameAddr(frameAddr),
    .frameData(frameData), .csFall(csFall), .statusIn(statusIn), .accIn(accIn),
    .rtzFlag(rtzFlag), .posIn(posIn), .stepIn(stepIn), .zeroIsCw(zeroIsCw),
    .coilSixty(coilSixty), .emuOff(emuOff), .calCenter(calCenter),
    .calArm(calArm), .calSlow(calSlow), .powerOn(powerOn), .rbWord(rbWord)
  );

  function automatic logic [WORD_W-1:0] expWord(input logic [2:0] sel, input logic err);
    if (sel[2] == 1'b0)     return {err, statusIn};
    else if (sel[1] == 1'b0) return {rtzFlag, accIn};
    else if (sel[0] == 1'b0) return posIn;
    else                     return stepIn;
  endfunction

  function automatic logic [6:0] cfgNow();
    return {zeroIsCw, coilSixty, emuOff, calCenter, calArm, calSlow, powerOn};
  endfunction

  task automatic check(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic randLive();
    statusIn = WORD_W'($urandom) ;
    accIn    = (WORD_W-1)'($urandom);
    rtzFlag  = 1'($urandom);
    posIn    = WORD_W'($urandom);
    stepIn   = WORD_W'($urandom);
  endtask

  task automatic sendFrame(input logic [ADDR_W-1:0] a, input logic [12:0] d, input string req);
    @(negedge clk);
    frameAddr = a; frameData = d; frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
    if (a == 0) begin
      if (d[12]) mErr = 1'b0;
      else if (d[8]) mErr = 1'b1;
      else begin
        mErr = 1'b0;
        mCfg = {d[7:2], d[0]};
        mSel = d[11:9];
      end
    end
    check(req, WORD_W'(cfgNow()), WORD_W'(mCfg));
  endtask

  task automatic snap(input string req);
    @(negedge clk);
    randLive();
    mWord = expWord(mSel, mErr);
    csFall = 1'b1;
    @(negedge clk);
    csFall = 1'b0;
    randLive();
    check(req, rbWord, mWord);
    repeat (2) @(negedge clk);
    randLive();
    @(negedge clk);
    check("R9 hold", rbWord, mWord);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R1 cfg", WORD_W'(cfgNow()), '0);
    check("R1 word", rbWord, '0);
    rstN = 1'b1;
    snap("R1 status default");

    // R2: all config bits high, select status
    sendFrame(0, 13'b0_0000_1111_1101, "R2 all ones");
    // R10: only bit 1 set acts as zero write
    sendFrame(0, 13'b0_0000_0000_0010, "R10 bit1");
    check("R10 cfg zero", WORD_W'(cfgNow()), '0);
    sendFrame(0, 13'b0_0000_1010_0101, "R2 pattern");
    // R3: null with everything else set
    sendFrame(0, 13'b1_1111_1111_1111, "R3 null");
    snap("R3 select kept");
    // R4: reject
    sendFrame(0, 13'b0_1101_0101_1010, "R4 reject");
    snap("R4 err visible");
    snap("R5 err sticky");
    sendFrame(0, 13'b1_0000_0000_0000, "R5 null clears");
    snap("R5 err cleared");
    // R6: other address
    sendFrame(3, 13'b0_1110_1111_1101, "R6 other addr");
    snap("R6 select kept");
    // R7/R8: each selector code
    sendFrame(0, 13'b0_1000_0000_0000, "R7 acc sel");
    snap("R7 acc");
    sendFrame(0, 13'b0_1010_0000_0001, "R7 acc alt");
    snap("R7 acc alt");
    sendFrame(0, 13'b0_1100_0000_0000, "R7 pos sel");
    snap("R8 pos");
    sendFrame(0, 13'b0_1110_0000_0000, "R7 step sel");
    snap("R8 step");
    sendFrame(0, 13'b0_0110_0000_0000, "R7 status sel");
    snap("R7 status dont care");

    for (int i = 0; i < 300; i++) begin
      logic [12:0] d;
      logic [ADDR_W-1:0] a;
      d = 13'($urandom);
      a = ($urandom % 6 == 0) ? ADDR_W'($urandom) : '0;
      if ($urandom % 4 != 0) d[12] = 1'b0;
      if ($urandom % 4 != 0) d[8] = 1'b0;
      sendFrame(a, d, "R2 random");
      snap("R8 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule